// File: doc/BRIEF.md
# DRAM Cycle Classifier

This block watches the control strobes of an asynchronous DRAM with two byte lanes. The strobes are the row strobe, a column strobe for each lane, write enable and output enable, all active low. It samples them on a fast reference clock, finds edges by comparing each sample with the one before, and works out which kind of memory cycle the controller is running. It also reports, for each lane, whether data is being written, driven out, or left in an undefined state. It stores no memory contents. It is meant to sit next to a controller under verification, either as a protocol checker or as the front end of a bus-functional memory model.

The cycle type is decided from the two column strobes combined: the first one to fall starts the column phase, and the cycle does not end until both have risen. Write and output-drive status is kept separately for each lane, gated by that lane's own strobe. A lane whose strobe falls later than the other lane's, with a write-enable level that would give it a different cycle type, is flagged as forbidden skew. This flag stays set until reset.

The class is coded as an index whose one-hot form appears on `cyc_type` and `done_type`:
- 0 standby
- 1 read
- 2 early write
- 3 delayed write
- 4 read-modify-write
- 5 CAS-before-RAS refresh
- 6 RAS-only refresh
- 7 output-disabled read

Lane 0 is the lower byte (`col_stb_n[0]`) and lane 1 is the upper byte. Every output is a register. It reflects the pin sample taken at the same clock edge.

Top module: `dram_cycle_classifier`

## Requirements
- R1: After reset, `cyc_type` is 8'b0000_0001 (standby) and `done_type` is 8'b0000_0001. `cyc_done`, `lane_wr`, `lane_drv`, `lane_undef`, `skew_evt` and `proto_err` are all zero.
- R2: A row strobe fall sampled while a column strobe was already low in the previous sample gives class 5 (CAS-before-RAS refresh). During that cycle no lane reports write, drive or undefined.
- R3: A row strobe fall with both column strobes high gives class 6. If no column strobe falls before the row strobe rises, the cycle completes as class 6 with no lane activity.
- R4: If write enable is low in the sample where the first column strobe falls, the class is 2 (early write). This includes write enable falling in that same sample. Each lane whose strobe is low with the row strobe low reports `lane_wr`.
- R5: A column phase that starts with write enable high is class 7. It becomes class 1 once output enable is sampled low with write enable high. `lane_drv[i]` is high while the row strobe is low, lane i's strobe is low, write enable is high and output enable is low.
- R6: A write enable fall after the column phase has started turns class 7 into class 3 (delayed write) and class 1 into class 4 (read-modify-write).
- R7: In classes 1, 3, 4 and 7, `lane_undef[i]` is high while the row strobe is low, lane i's strobe is low, write enable is low and output enable is high. In class 2 it stays low.
- R8: A cycle completes in the first sample with the row strobe and both column strobes high. `cyc_done` then pulses for one clock, `done_type` takes the cycle's class, and `cyc_type` returns to standby.
- R9: If the row strobe falls again while a column strobe has been held low since the previous sample, the running cycle completes (`cyc_done`, `done_type`) and a class 5 cycle starts in the same clock.
- R10: If the row strobe fall and the first column strobe fall land in the same sample, the cycle is an access and not a refresh. With write enable and output enable high, it is class 7.
- R11: A lane strobe may fall in a later sample than the other lane's, which stayed low. If write enable is low there in a non-early-write cycle, or high there in an early-write cycle, `skew_evt` pulses and `proto_err` sets and holds until reset. A later lane with a matching write-enable level raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 2 | Column strobes, bit 0 lower lane, bit 1 upper lane, active low |
| wr_en_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| cyc_type | output | 8 | One-hot class of the cycle in progress |
| cyc_done | output | 1 | One-clock pulse when a cycle completes |
| done_type | output | 8 | One-hot class of the last completed cycle |
| lane_wr | output | 2 | Per-lane write in progress |
| lane_drv | output | 2 | Per-lane output driven with read data |
| lane_undef | output | 2 | Per-lane output undefined |
| skew_evt | output | 1 | One-clock pulse on forbidden lane skew |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
Two events can fall in one sample: the completion of one cycle and the start of the next, and a class decision coinciding with the edge that decides it. Hidden refresh is provoked by raising and re-lowering the row strobe while a column strobe is held low. It is judged by seeing `cyc_done` with `done_type` of the read and `cyc_type` of refresh in the same clock. The same-sample ties are forced by moving the row strobe with the first column strobe, and write enable with the first column strobe. Each is judged against the fixed order: row before column, and write enable before output enable.

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       row_stb_n,
  input  logic [1:0] col_stb_n,
  input  logic       wr_en_n,
  input  logic       out_en_n,
  output logic [7:0] cyc_type,
  output logic       cyc_done,
  output logic [7:0] done_type,
  output logic [1:0] lane_wr,
  output logic [1:0] lane_drv,
  output logic [1:0] lane_undef,
  output logic       skew_evt,
  output logic       proto_err
);

  localparam logic [2:0] K_STBY  = 3'd0;
  localparam logic [2:0] K_READ  = 3'd1;
  localparam logic [2:0] K_EWR   = 3'd2;
  localparam logic [2:0] K_DWR   = 3'd3;
  localparam logic [2:0] K_RMW   = 3'd4;
  localparam logic [2:0] K_CBR   = 3'd5;
  localparam logic [2:0] K_RONLY = 3'd6;
  localparam logic [2:0] K_ODIS  = 3'd7;

  logic       p_row, p_we;
  logic [1:0] p_col;
  logic       busy, busy_d;
  logic [2:0] cls, cls_d;
  logic       done_d, skew_d;

  wire       row_fall  = p_row & ~row_stb_n;
  wire       col_on    = ~&col_stb_n;
  wire       p_col_on  = ~&p_col;
  wire       col_first = ~p_col_on & col_on;
  wire       we_fall   = p_we & ~wr_en_n;
  wire [1:0] lane_fall = p_col & ~col_stb_n;
  wire       late_lane = (lane_fall[0] & ~p_col[1]) | (lane_fall[1] & ~p_col[0]);

  function automatic logic is_access(input logic [2:0] k);
    return (k == K_READ) || (k == K_ODIS) || (k == K_EWR) || (k == K_DWR) || (k == K_RMW);
  endfunction

  function automatic logic [2:0] col_start(input logic we_n, input logic oe_n);
    if (!we_n)     return K_EWR;
    else if (!oe_n) return K_READ;
    else            return K_ODIS;
  endfunction

  always_comb begin
    busy_d = busy;
    cls_d  = cls;
    done_d = 1'b0;
    skew_d = busy && is_access(cls) && late_lane && ((cls == K_EWR) == wr_en_n);
    if (!busy) begin
      if (row_fall) begin
        busy_d = 1'b1;
        if (p_col_on)    cls_d = K_CBR;
        else if (col_on) cls_d = col_start(wr_en_n, out_en_n);
        else             cls_d = K_RONLY;
      end
    end else if (row_fall && p_col_on) begin
      done_d = 1'b1;
      cls_d  = K_CBR;
    end else if (row_stb_n && !col_on) begin
      done_d = 1'b1;
      busy_d = 1'b0;
      cls_d  = K_STBY;
    end else begin
      case (cls)
        K_RONLY:
          if (col_first && !row_stb_n) cls_d = col_start(wr_en_n, out_en_n);
        K_READ, K_ODIS:
          if (we_fall)
            cls_d = (cls == K_READ) ? K_RMW : K_DWR;
          else if (cls == K_ODIS && !out_en_n && wr_en_n && !row_stb_n)
            cls_d = K_READ;
        default: ;
      endcase
    end
  end

  wire       acc_d   = busy_d & is_access(cls_d) & ~row_stb_n;
  wire [1:0] lane_on = ~col_stb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_row      <= 1'b1;
      p_col      <= 2'b11;
      p_we       <= 1'b1;
      busy       <= 1'b0;
      cls        <= K_STBY;
      cyc_done   <= 1'b0;
      done_type  <= 8'b0000_0001;
      lane_wr    <= 2'b00;
      lane_drv   <= 2'b00;
      lane_undef <= 2'b00;
      skew_evt   <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      p_row      <= row_stb_n;
      p_col      <= col_stb_n;
      p_we       <= wr_en_n;
      busy       <= busy_d;
      cls        <= cls_d;
      cyc_done   <= done_d;
      if (done_d) done_type <= 8'(1) << cls;
      lane_wr    <= {2{acc_d & ~wr_en_n}} & lane_on;
      lane_drv   <= {2{acc_d & wr_en_n & ~out_en_n}} & lane_on;
      lane_undef <= {2{acc_d & ~wr_en_n & out_en_n & (cls_d != K_EWR)}} & lane_on;
      skew_evt   <= skew_d;
      proto_err  <= proto_err | skew_d;
    end
  end

  assign cyc_type = 8'(1) << cls;

endmodule

// File: rtl/dram_cycle_classifier_chk.sv
module dram_cycle_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cyc_type,
  input logic       cyc_done,
  input logic [7:0] done_type,
  input logic [1:0] lane_wr,
  input logic [1:0] lane_drv,
  input logic [1:0] lane_undef,
  input logic       skew_evt,
  input logic       proto_err
);

  a_r1_type_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cyc_type));

  a_r2_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type[5] |-> (lane_wr == 2'b00 && lane_drv == 2'b00 && lane_undef == 2'b00));

  a_r3_ras_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type[6] |-> (lane_wr == 2'b00 && lane_drv == 2'b00));

  a_r4_early_write_open: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type[2] |-> (lane_drv == 2'b00 && lane_undef == 2'b00));

  a_r5_drive_not_write: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_drv & lane_wr) == 2'b00);

  a_r7_undef_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_undef & ~lane_wr) == 2'b00);

  a_r8_done_type_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> ($onehot(done_type) && !done_type[0]));

  a_r11_skew_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    skew_evt |-> proto_err);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

bind dram_cycle_classifier dram_cycle_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .cyc_done(cyc_done),
  .done_type(done_type), .lane_wr(lane_wr), .lane_drv(lane_drv),
  .lane_undef(lane_undef), .skew_evt(skew_evt), .proto_err(proto_err)
);

// File: tb/test_dram_cycle_classifier.sv
module test_dram_cycle_classifier;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       row_stb_n = 1'b1;
  logic [1:0] col_stb_n = 2'b11;
  logic       wr_en_n = 1'b1;
  logic       out_en_n = 1'b1;
  logic [7:0] cyc_type, done_type;
  logic       cyc_done, skew_evt, proto_err;
  logic [1:0] lane_wr, lane_drv, lane_undef;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dram_cycle_classifier i_dram_cycle_classifier (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_en_n(wr_en_n), .out_en_n(out_en_n), .cyc_type(cyc_type), .cyc_done(cyc_done),
    .done_type(done_type), .lane_wr(lane_wr), .lane_drv(lane_drv),
    .lane_undef(lane_undef), .skew_evt(skew_evt), .proto_err(proto_err)
  );

  // row = {pins {row,colL,colH,we,oe}, class, done, last class, wr, drv}
  localparam int NV = 27;
  localparam logic [15:0] VEC [NV] = '{
    {5'b11111, 3'd0, 1'b0, 3'd0, 2'b00, 2'b00},
    {5'b01111, 3'd6, 1'b0, 3'd0, 2'b00, 2'b00},
    {5'b00011, 3'd7, 1'b0, 3'd0, 2'b00, 2'b00},
    {5'b00010, 3'd1, 1'b0, 3'd0, 2'b00, 2'b11},
    {5'b10010, 3'd1, 1'b0, 3'd0, 2'b00, 2'b00},
    {5'b11110, 3'd0, 1'b1, 3'd1, 2'b00, 2'b00},
    {5'b01111, 3'd6, 1'b0, 3'd1, 2'b00, 2'b00},
    {5'b00101, 3'd2, 1'b0, 3'd1, 2'b01, 2'b00},
    {5'b11111, 3'd0, 1'b1, 3'd2, 2'b00, 2'b00},
    {5'b01111, 3'd6, 1'b0, 3'd2, 2'b00, 2'b00},
    {5'b01011, 3'd7, 1'b0, 3'd2, 2'b00, 2'b00},
    {5'b01001, 3'd3, 1'b0, 3'd2, 2'b10, 2'b00},
    {5'b11111, 3'd0, 1'b1, 3'd3, 2'b00, 2'b00},
    {5'b01111, 3'd6, 1'b0, 3'd3, 2'b00, 2'b00},
    {5'b00010, 3'd1, 1'b0, 3'd3, 2'b00, 2'b11},
    {5'b00011, 3'd1, 1'b0, 3'd3, 2'b00, 2'b00},
    {5'b00001, 3'd4, 1'b0, 3'd3, 2'b11, 2'b00},
    {5'b11111, 3'd0, 1'b1, 3'd4, 2'b00, 2'b00},
    {5'b10111, 3'd0, 1'b0, 3'd4, 2'b00, 2'b00},
    {5'b00111, 3'd5, 1'b0, 3'd4, 2'b00, 2'b00},
    {5'b10111, 3'd5, 1'b0, 3'd4, 2'b00, 2'b00},
    {5'b11111, 3'd0, 1'b1, 3'd5, 2'b00, 2'b00},
    {5'b01111, 3'd6, 1'b0, 3'd5, 2'b00, 2'b00},
    {5'b11111, 3'd0, 1'b1, 3'd6, 2'b00, 2'b00},
    {5'b01111, 3'd6, 1'b0, 3'd6, 2'b00, 2'b00},
    {5'b00011, 3'd7, 1'b0, 3'd6, 2'b00, 2'b00},
    {5'b11111, 3'd0, 1'b1, 3'd7, 2'b00, 2'b00}
  };

  task automatic put(input logic [4:0] p);
    @(negedge clk);
    row_stb_n = p[4];
    col_stb_n = {p[2], p[3]};
    wr_en_n   = p[1];
    out_en_n  = p[0];
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    row_stb_n = 1'b1; col_stb_n = 2'b11; wr_en_n = 1'b1; out_en_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  function automatic logic [7:0] oh(input logic [2:0] k);
    return 8'(1) << k;
  endfunction

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(cyc_type == 8'h01 && done_type == 8'h01, "R1 types", {cyc_type, done_type}, 32'h0101);
    chk({cyc_done, lane_wr, lane_drv, lane_undef, skew_evt, proto_err} == 0, "R1 flags",
        {cyc_done, lane_wr, lane_drv, lane_undef, skew_evt, proto_err}, 0);

    // table: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      put(v[15:11]);
      chk(cyc_type == oh(v[10:8]) && cyc_done == v[7] && done_type == oh(v[6:4]) &&
          lane_wr == v[3:2] && lane_drv == v[1:0],
          $sformatf("vec %0d R2 R3 R4 R5 R6 R8", i),
          {cyc_type, cyc_done, done_type, lane_wr, lane_drv},
          {oh(v[10:8]), v[7], oh(v[6:4]), v[3:2], v[1:0]});
    end

    // R10 row and column fall together: access, not refresh
    put(5'b00011);
    chk(cyc_type == oh(3'd7), "R10 tie row/col", cyc_type, oh(3'd7));
    put(5'b11111);
    chk(cyc_done && done_type == oh(3'd7), "R10 done", done_type, oh(3'd7));

    // R4 write enable with first column fall: early write; R7 no undef
    put(5'b01111);
    put(5'b00001);
    chk(cyc_type == oh(3'd2) && lane_wr == 2'b11, "R4 tie we/col", {cyc_type, lane_wr}, {oh(3'd2), 2'b11});
    chk(lane_undef == 2'b00, "R7 early write open", lane_undef, 0);
    put(5'b11111);

    // R7 delayed write with oe high: undefined
    put(5'b01111);
    put(5'b00011);
    put(5'b00001);
    chk(lane_undef == 2'b11 && cyc_type == oh(3'd3), "R7 undef", {cyc_type, lane_undef}, {oh(3'd3), 2'b11});
    put(5'b11111);

    // R9 hidden refresh
    put(5'b01111);
    put(5'b00010);
    put(5'b10010);
    chk(!cyc_done && cyc_type == oh(3'd1), "R9 held", {cyc_done, cyc_type}, {1'b0, oh(3'd1)});
    put(5'b00010);
    chk(cyc_done && done_type == oh(3'd1) && cyc_type == oh(3'd5), "R9 switch",
        {cyc_done, done_type, cyc_type}, {1'b1, oh(3'd1), oh(3'd5)});
    chk(lane_drv == 2'b00, "R2 refresh no drive", lane_drv, 0);
    put(5'b11111);
    chk(cyc_done && done_type == oh(3'd5), "R9 refresh done", done_type, oh(3'd5));

    // R11 staggered lanes with matching write enable: no flag
    put(5'b01111);
    put(5'b00111);
    put(5'b00011);
    chk(!skew_evt && !proto_err, "R11 legal stagger", {skew_evt, proto_err}, 0);
    put(5'b11111);

    // R11 forbidden skew
    put(5'b01111);
    put(5'b00111);
    put(5'b00001);
    chk(skew_evt && proto_err, "R11 skew flagged", {skew_evt, proto_err}, 2'b11);
    put(5'b11111);
    put(5'b11111);
    chk(!skew_evt && proto_err, "R11 sticky", {skew_evt, proto_err}, 2'b01);

    do_reset();
    chk(!proto_err && cyc_type == 8'h01, "R1 reset clears", {proto_err, cyc_type}, 9'h001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule